// File: doc/BRIEF.md
# Serial Clock-and-Scratchpad Slave

This block is a serial slave that holds a 32-bit seconds counter and a 64-byte scratch memory behind a four-wire link made of select, serial clock, data in and data out. A host opens an access by pulling select low and shifting in a 32-bit command word. The top bit of the command is the write flag. The other 31 bits are the address. Depending on that address, the block then returns or accepts 32 data bits, or it streams the scratch memory one word after another. Raising select ends the access at any point.

The serial pins are sampled in the block's own clock domain. The host must therefore hold each serial clock level for at least three system clock cycles, and the pins must already be synchronous. Input bits are taken on the rising serial clock edge. Output bits change after the falling edge. A one-cycle tick input advances the counter, normally once a second. Counter reads capture a snapshot, so a transfer that is under way can never return a torn value.

Top module: `rtcs_slave`

## Requirements
- R1: After a synchronous active-low reset, the data output is 0, the counter reads 0 and every scratch word reads 0.
- R2: The command word is shifted most-significant bit first. Bit 31 set to 1 makes the access a write. Bit 31 clear makes it a read. Bits 30..0 are the address. When the command is a read, data bits the host shifts in afterwards change nothing.
- R3: A read of address 0x20000000 returns the counter value as 32 bits, most-significant bit first. Each bit is valid after the falling serial clock edge that follows the command word or the previous bit. Bits after those 32 are 0.
- R4: Every cycle with the tick input high adds one to the counter, and 0xFFFFFFFF wraps to 0. Without a tick or a load, the counter holds its value.
- R5: A write to address 0x20000000 loads the 32 data bits into the counter when the 32nd data bit arrives. A tick in the same cycle as that load is lost.
- R6: The value a counter read returns is captured when the command word completes. A tick during the data phase does not change it, but a later read sees the tick.
- R7: A write to address 0x20000100 + 4k (k = 0..15) stores its 32 data bits in scratch word k. The two low address bits are ignored.
- R8: A read of a scratch address returns that word and then the following words in ascending order, 32 bits each, for as long as select stays low. After word 15 it continues with word 0.
- R9: A read of address 0x00000000 returns the identification value 0xFFFFF308.
- R10: A read of any other address returns zeros. A write to any other address, or to the identification address, changes no state.
- R11: If select rises before the 32nd data bit of a write, nothing is committed. If it rises inside a command word, the partial command is discarded.
- R12: The data output is 0 during the command word and in the cycle after any cycle with select high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_tick | input | 1 | One-cycle pulse that advances the counter |
| sel_n | input | 1 | Active-low frame select from the host |
| sclk | input | 1 | Serial clock from the host, idle low |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |

## Verification
Several properties are checked on every cycle. The counter steps by exactly one on a tick, holds without one, and takes the shifted word on a load. The output stays quiet while the block is deselected and changes only after a falling serial edge. The command-complete and word-complete strobes never coincide. Only the bench scenarios can show the address decode, the snapshot timing, the order and wrap of bursts, the tick lost at a commit, and the absence of any commit after an aborted frame. The bench sweeps every scratch word, every burst start offset and every abort position against a model of the memory and counter.

// File: rtl/rtcs_pkg.sv
// Package: shared constants, region type and address classifier for the
// serial clock-and-scratchpad slave. Assumes a 32-bit command word.
package rtcs_pkg;

    localparam int unsigned  WORD_W    = 32;
    localparam logic [30:0]  CLK_ADDR  = 31'h2000_0000;
    localparam logic [30:0]  MEM_ADDR  = 31'h2000_0100;
    localparam logic [30:0]  IDQ_ADDR  = 31'h0000_0000;
    localparam logic [31:0]  ID_VALUE  = 32'hFFFF_F308;

    typedef enum logic [1:0] {
        REG_NONE  = 2'd0,
        REG_CLOCK = 2'd1,
        REG_MEM   = 2'd2,
        REG_IDENT = 2'd3
    } region_e;

    // Map a 31-bit address onto the region it selects.
    function automatic region_e classify(input logic [30:0] addr,
                                         input logic [30:0] mem_bytes);
        region_e r;
        r = REG_NONE;
        if (addr == CLK_ADDR)
            r = REG_CLOCK;
        else if (addr == IDQ_ADDR)
            r = REG_IDENT;
        else if ((addr >= MEM_ADDR) && ((addr - MEM_ADDR) < mem_bytes))
            r = REG_MEM;
        return r;
    endfunction

endpackage

// File: rtl/rtcs_frame_rx.sv
// Module: frame receiver. Detects serial clock edges by oversampling in the
// system clock domain, shifts in data MSB first on rising edges and marks
// the end of the command word and of every later 32-bit data word.
// Assumes sclk, sel_n and mosi are already synchronous and each sclk level
// lasts at least three system cycles.
module rtcs_frame_rx #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sel_n,
    input  logic         sclk,
    input  logic         mosi,
    output logic         sclk_fall,
    output logic         cmd_done,
    output logic         word_done,
    output logic         data_phase,
    output logic [W-1:0] rx_word
);
    localparam int unsigned   CNT_W    = $clog2(W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(W - 1);

    logic             sclk_q;
    logic             sclk_rise;
    logic [CNT_W-1:0] bit_cnt;

    assign sclk_rise = sclk & ~sclk_q & ~sel_n;
    assign sclk_fall = ~sclk & sclk_q & ~sel_n;

    // Edge history, bit counting, shift register and word strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q     <= 1'b0;
            bit_cnt    <= '0;
            data_phase <= 1'b0;
            cmd_done   <= 1'b0;
            word_done  <= 1'b0;
            rx_word    <= '0;
        end else begin
            sclk_q    <= sclk;
            cmd_done  <= 1'b0;
            word_done <= 1'b0;
            if (sel_n) begin
                bit_cnt    <= '0;
                data_phase <= 1'b0;
            end else if (sclk_rise) begin
                rx_word <= {rx_word[W-2:0], mosi};
                if (bit_cnt == CNT_LAST) begin
                    bit_cnt    <= '0;
                    data_phase <= 1'b1;
                    if (data_phase)
                        word_done <= 1'b1;
                    else
                        cmd_done  <= 1'b1;
                end else begin
                    bit_cnt <= bit_cnt + CNT_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/rtcs_sec_counter.sv
// Module: seconds counter. Adds one per tick cycle and wraps at full scale.
// A load takes priority, so a tick in the load cycle is lost.
module rtcs_sec_counter #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] count
);
    // Counter register with load-over-tick priority.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (load)
            count <= load_val;
        else if (tick)
            count <= count + W'(1);
    end

endmodule

// File: rtl/rtcs_word_store.sv
// Module: scratch word store with one write port and one asynchronous read
// port. WORDS must be a power of two so that every index is valid.
module rtcs_word_store #(
    parameter int unsigned W     = 32,
    parameter int unsigned WORDS = 16,
    localparam int unsigned IDX_W = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [W-1:0]     wdata,
    input  logic [IDX_W-1:0] raddr,
    output logic [W-1:0]     rdata
);
    logic [W-1:0] word_view [WORDS];

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        logic [W-1:0] word_q;

        // One storage word, cleared by reset, written when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n)
                word_q <= '0;
            else if (we && (waddr == IDX_W'(g)))
                word_q <= wdata;
        end

        assign word_view[g] = word_q;
    end

    assign rdata = word_view[raddr];

endmodule

// File: rtl/rtcs_slave.sv
// Module: top of the serial clock-and-scratchpad slave. Decodes the command
// word, snapshots read data into a transmit register, streams it out after
// falling serial edges, reloads successive scratch words during bursts and
// commits a write once its 32nd data bit has arrived.
// Assumes the host keeps select low for the whole access.
module rtcs_slave #(
    parameter int unsigned MEM_BYTES = 64,
    localparam int unsigned W        = rtcs_pkg::WORD_W,
    localparam int unsigned WORDS    = MEM_BYTES / 4,
    localparam int unsigned IDX_W    = $clog2(WORDS),
    localparam int unsigned BIT_W    = $clog2(W)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sec_tick,
    input  logic sel_n,
    input  logic sclk,
    input  logic mosi,
    output logic miso
);
    import rtcs_pkg::*;

    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(W - 1);

    logic             sclk_fall;
    logic             cmd_done;
    logic             word_done;
    logic             data_phase;
    logic [W-1:0]     rx_word;

    logic [W-1:0]     sec_q;
    logic             cnt_load;
    logic             mem_we;
    logic [IDX_W-1:0] rd_idx;
    logic [W-1:0]     rd_data;

    region_e          dec_region;
    logic [IDX_W-1:0] start_idx;
    logic [W-1:0]     first_word;

    region_e          region_q;
    logic             wr_arm;
    logic             burst_q;
    logic [IDX_W-1:0] ptr;
    logic [BIT_W-1:0] bit_ix;
    logic [W-1:0]     tx;
    logic             miso_r;

    rtcs_frame_rx #(.W(W)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_n      (sel_n),
        .sclk       (sclk),
        .mosi       (mosi),
        .sclk_fall  (sclk_fall),
        .cmd_done   (cmd_done),
        .word_done  (word_done),
        .data_phase (data_phase),
        .rx_word    (rx_word)
    );

    rtcs_sec_counter #(.W(W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (sec_tick),
        .load     (cnt_load),
        .load_val (rx_word),
        .count    (sec_q)
    );

    rtcs_word_store #(.W(W), .WORDS(WORDS)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr (ptr),
        .wdata (rx_word),
        .raddr (rd_idx),
        .rdata (rd_data)
    );

    // Classify the address of the command word just received.
    always_comb begin
        dec_region = classify(rx_word[30:0], 31'(MEM_BYTES));
        start_idx  = IDX_W'((rx_word[30:0] - MEM_ADDR) >> 2);
    end

    // Share one read port between the burst start and later reloads.
    assign rd_idx = cmd_done ? start_idx : ptr;

    // Pick the word captured when the command completes.
    always_comb begin
        case (dec_region)
            REG_CLOCK: first_word = sec_q;
            REG_MEM:   first_word = rd_data;
            REG_IDENT: first_word = ID_VALUE;
            default:   first_word = '0;
        endcase
    end

    // Write commit strobes, one per frame, on the first data word only.
    assign cnt_load = word_done && wr_arm && (region_q == REG_CLOCK);
    assign mem_we   = word_done && wr_arm && (region_q == REG_MEM);

    // Frame state: decode latch, write arming, burst pointer, transmit shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            region_q <= REG_NONE;
            wr_arm   <= 1'b0;
            burst_q  <= 1'b0;
            ptr      <= '0;
            bit_ix   <= '0;
            tx       <= '0;
            miso_r   <= 1'b0;
        end else if (sel_n) begin
            region_q <= REG_NONE;
            wr_arm   <= 1'b0;
            burst_q  <= 1'b0;
            bit_ix   <= '0;
            tx       <= '0;
            miso_r   <= 1'b0;
        end else begin
            if (cmd_done) begin
                region_q <= dec_region;
                wr_arm   <= rx_word[W-1];
                burst_q  <= !rx_word[W-1] && (dec_region == REG_MEM);
                ptr      <= rx_word[W-1] ? start_idx : start_idx + IDX_W'(1);
                bit_ix   <= '0;
                tx       <= rx_word[W-1] ? '0 : first_word;
            end else begin
                if (word_done)
                    wr_arm <= 1'b0;
                if (sclk_fall && data_phase) begin
                    miso_r <= tx[W-1];
                    if (bit_ix == BIT_LAST) begin
                        bit_ix <= '0;
                        if (burst_q) begin
                            tx  <= rd_data;
                            ptr <= ptr + IDX_W'(1);
                        end else begin
                            tx  <= '0;
                        end
                    end else begin
                        bit_ix <= bit_ix + BIT_W'(1);
                        tx     <= {tx[W-2:0], 1'b0};
                    end
                end
            end
        end
    end

    assign miso = miso_r;

endmodule

// File: rtl/rtcs_slave_chk.sv
// Module: property checker for rtcs_slave, bound to every instance.
module rtcs_slave_chk #(
    parameter int unsigned W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         sel_n,
    input logic         sec_tick,
    input logic         miso,
    input logic [W-1:0] sec_q,
    input logic         cnt_load,
    input logic [W-1:0] load_val,
    input logic         sclk_fall,
    input logic         cmd_done,
    input logic         word_done
);
    AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && !cnt_load) |=> (sec_q == $past(sec_q) + W'(1))); // R4
    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!sec_tick && !cnt_load) |=> $stable(sec_q)); // R4
    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_load |=> (sec_q == $past(load_val))); // R5
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n |=> !miso); // R12
    AST_OUT_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && !sclk_fall) |=> $stable(miso)); // R3
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_done, word_done})); // R2
    AST_CMD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |=> !cmd_done); // R2
endmodule

bind rtcs_slave rtcs_slave_chk #(.W(32)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_n     (sel_n),
    .sec_tick  (sec_tick),
    .miso      (miso),
    .sec_q     (sec_q),
    .cnt_load  (cnt_load),
    .load_val  (rx_word),
    .sclk_fall (sclk_fall),
    .cmd_done  (cmd_done),
    .word_done (word_done)
);

// File: tb/rtcs_slave_tb.sv
module rtcs_slave_tb;

    localparam logic [31:0] A_CLK  = 32'h2000_0000;
    localparam logic [31:0] A_MEM  = 32'h2000_0100;
    localparam logic [31:0] A_ID   = 32'h0000_0000;
    localparam logic [31:0] WR     = 32'h8000_0000;
    localparam logic [31:0] ID_EXP = 32'hFFFF_F308;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sec_tick = 1'b0;
    logic sel_n = 1'b1;
    logic sclk = 1'b0;
    logic mosi = 1'b0;
    logic miso;

    int chk_cnt = 0;
    int fail_cnt = 0;
    int bit_no = 0;
    int tick_bit = -1;
    bit finished = 1'b0;

    logic [31:0] exp_mem [16];
    logic [31:0] exp_sec;
    logic [31:0] rbuf [17];

    always #4 clk = ~clk;

    rtcs_slave u_dut (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
        .sel_n(sel_n), .sclk(sclk), .mosi(mosi), .miso(miso)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        chk_cnt++;
        if (act !== exp) begin
            fail_cnt++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic sel_on();
        @(negedge clk) sel_n = 1'b0;
        bit_no = 0;
        repeat (3) @(negedge clk);
    endtask

    task automatic sel_off();
        @(negedge clk) sclk = 1'b0;
        repeat (3) @(negedge clk);
        sel_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic xbit(input logic b, output logic o);
        @(negedge clk) sclk = 1'b0;
        mosi = b;
        repeat (3) @(negedge clk);
        o = miso;
        sclk = 1'b1;
        bit_no++;
        if (bit_no == tick_bit) begin
            @(negedge clk) sec_tick = 1'b1;
            @(negedge clk) sec_tick = 1'b0;
            repeat (2) @(negedge clk);
        end else begin
            repeat (4) @(negedge clk);
        end
    endtask

    task automatic xword(input logic [31:0] w, output logic [31:0] r);
        for (int i = 31; i >= 0; i--) begin
            logic o;
            xbit(w[i], o);
            r[i] = o;
        end
    endtask

    // Read frame: command then n data words into rbuf; command phase output must be 0.
    task automatic rd_frame(input logic [31:0] cmd, input int n);
        logic [31:0] r;
        sel_on();
        xword(cmd, r);
        chk("R12 quiet during command", r, 32'h0);
        for (int k = 0; k < n; k++) begin
            xword(32'h0, r);
            rbuf[k] = r;
        end
        sel_off();
    endtask

    task automatic wr_frame(input logic [31:0] addr, input logic [31:0] data);
        logic [31:0] r;
        sel_on();
        xword(addr | WR, r);
        xword(data, r);
        sel_off();
    endtask

    task automatic part_frame(input logic [31:0] cmd, input logic [31:0] data, input int nbits);
        logic [31:0] r;
        logic o;
        sel_on();
        xword(cmd, r);
        for (int i = 0; i < nbits; i++) xbit(data[31-i], o);
        sel_off();
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) sec_tick = 1'b1;
            @(negedge clk) sec_tick = 1'b0;
        end
    endtask

    task automatic mem_all(input string req);
        rd_frame(A_MEM, 16);
        for (int k = 0; k < 16; k++) chk(req, rbuf[k], exp_mem[k]);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            fail_cnt++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
            $display("End of test - %0d assertions evaluated, %0d failures", chk_cnt, fail_cnt);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        for (int k = 0; k < 16; k++) exp_mem[k] = 32'h0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 miso after reset", {31'h0, miso}, 32'h0);

        // R1: counter and memory clear after reset
        rd_frame(A_CLK, 1);
        chk("R1 counter after reset", rbuf[0], 32'h0);
        mem_all("R1 memory after reset");

        // R9 identification, R3 trailing zeros
        rd_frame(A_ID, 2);
        chk("R9 identification", rbuf[0], ID_EXP);
        chk("R3 trailing bits zero", rbuf[1], 32'h0);

        // R4 tick counting
        ticks(5);
        exp_sec = 32'd5;
        rd_frame(A_CLK, 2);
        chk("R4 counter after ticks", rbuf[0], exp_sec);
        chk("R3 bits after counter word", rbuf[1], 32'h0);

        // R5 load, R4 wrap
        wr_frame(A_CLK, 32'hFFFF_FFFE);
        rd_frame(A_CLK, 1);
        chk("R5 counter load", rbuf[0], 32'hFFFF_FFFE);
        ticks(2);
        rd_frame(A_CLK, 1);
        chk("R4 counter wrap", rbuf[0], 32'h0);

        // R5 tick coincident with the commit is lost
        tick_bit = 64;
        wr_frame(A_CLK, 32'h1234_5678);
        tick_bit = -1;
        rd_frame(A_CLK, 1);
        chk("R5 tick at commit dropped", rbuf[0], 32'h1234_5678);

        // R6 snapshot during read
        tick_bit = 45;
        rd_frame(A_CLK, 1);
        tick_bit = -1;
        chk("R6 snapshot untouched", rbuf[0], 32'h1234_5678);
        rd_frame(A_CLK, 1);
        exp_sec = 32'h1234_5679;
        chk("R6 later read sees tick", rbuf[0], exp_sec);

        // R7 fill every word, one with a misaligned address
        for (int k = 0; k < 16; k++) begin
            logic [31:0] v;
            v = 32'hA500_003C ^ (32'(k) * 32'h0101_0101) ^ (32'(k) << 28);
            exp_mem[k] = v;
            wr_frame(A_MEM + 32'(4 * k) + ((k == 3) ? 32'd2 : 32'd0), v);
        end
        rd_frame(A_MEM + 32'd12, 1);
        chk("R7 misaligned write word 3", rbuf[0], exp_mem[3]);
        rd_frame(A_MEM + 32'd29, 1);
        chk("R7 misaligned read word 7", rbuf[0], exp_mem[7]);

        // R8 bursts from every start word, 17 words to show the wrap
        for (int s = 0; s < 16; s++) begin
            rd_frame(A_MEM + 32'(4 * s), 17);
            for (int k = 0; k < 17; k++)
                chk("R8 burst order", rbuf[k], exp_mem[(s + k) % 16]);
        end

        // R2 data shifted in after a read command is ignored
        sel_on();
        xword(A_MEM + 32'd8, r);
        xword(32'hFFFF_FFFF, r);
        sel_off();
        chk("R2 read returns word 2", r, exp_mem[2]);
        rd_frame(A_MEM + 32'd8, 1);
        chk("R2 read command wrote nothing", rbuf[0], exp_mem[2]);

        // R10 unmapped reads and ignored writes
        rd_frame(32'h2000_0200, 1);
        chk("R10 unmapped read above memory", rbuf[0], 32'h0);
        rd_frame(32'h2000_0040, 1);
        chk("R10 unmapped read below memory", rbuf[0], 32'h0);
        wr_frame(32'h2000_0200, 32'hDEAD_BEEF);
        wr_frame(32'h2000_00FC, 32'hDEAD_BEEF);
        wr_frame(A_ID, 32'h0BAD_F00D);
        rd_frame(A_ID, 1);
        chk("R10 identification unchanged", rbuf[0], ID_EXP);
        rd_frame(A_CLK, 1);
        chk("R10 counter unchanged", rbuf[0], exp_sec);
        mem_all("R10 memory unchanged");

        // R11 aborted frames at several positions
        for (int n = 0; n < 32; n += 5) begin
            part_frame(A_CLK | WR, 32'h0F0F_0F0F, n);
            rd_frame(A_CLK, 1);
            chk("R11 aborted counter write", rbuf[0], exp_sec);
        end
        part_frame(A_MEM + 32'd28 | WR, 32'h5555_AAAA, 31);
        rd_frame(A_MEM + 32'd28, 1);
        chk("R11 aborted memory write", rbuf[0], exp_mem[7]);
        sel_on();
        for (int i = 0; i < 16; i++) begin
            logic o;
            xbit(WR[31-i], o);
        end
        sel_off();
        rd_frame(A_ID, 1);
        chk("R11 partial command discarded", rbuf[0], ID_EXP);
        mem_all("R11 memory after aborts");

        repeat (2) @(negedge clk);
        chk("R12 quiet while deselected", {31'h0, miso}, 32'h0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", chk_cnt, fail_cnt);
        $finish;
    end

endmodule